// File: doc/BRIEF.md
# Decimating Integrate-and-Dump Matched Filter

This block is the matched filter for PSK baseband demodulation. It takes complex samples, one signed value each for I and Q, qualified by a valid strobe. Each rail sums a run of 2^c valid samples, where c is a 4-bit decimation code. A programmable arithmetic right shift then scales the sum back down. Each scaled result is a dump. The block adds every two consecutive dumps, without overlap, so the output rate is one result per 2^(c+1) valid samples.

A symbol-timing strobe realigns the accumulation and pairing to a chosen sample. For offset-QPSK, an enable delays the Q rail by one dump, which is half a symbol, so that I and Q decisions line up.

The configuration inputs are expected to change only while reset is held or just before a timing strobe. A decimation code outside the defined set is treated as the smallest decimation and sets a sticky error flag.

Top module: `idf_top`

## Requirements
- R1: While and just after synchronous active-low reset, out_valid, i_out, q_out and cfg_err are all 0. The Q delay register also starts at 0.
- R2: With dec_code c in 0..4, each dump is the sum of 2^c samples accepted with in_valid=1. Cycles with in_valid=0 neither add to the sum nor advance the count.
- R3: A dump is the accumulated sum arithmetically shifted right by shift_amt, rounding toward minus infinity. Values of shift_amt above 4 act as 4.
- R4: Dumps are paired without overlap, so i_out = dump(2k) + dump(2k+1). out_valid is 1 for exactly one clock, in the cycle after the sample that completes dump 2k+1. Between strobes the outputs hold their value.
- R5: With oqpsk_en=0, q_out pairs the Q dumps the same way as I. With oqpsk_en=1, q_out = qdump(2k-1) + qdump(2k), where qdump(-1) = 0 after reset. Both rails update on the same strobe.
- R6: A valid sample with sym_sync=1 starts a new accumulation. Any partial sum is discarded, and the dump it begins is the first of a new pair.
- R7: A dec_code value of 5..15 makes the block behave as code 0. cfg_err becomes 1 in the following cycle and stays 1 until reset.
- R8: Full-scale input does not overflow. 32 samples of -512 at code 4 with shift 0 give -16384, and 32 samples of +511 give 16352.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| sym_sync | input | 1 | Symbol-timing strobe, realigns accumulation (with in_valid) |
| i_in | input | 10 | In-phase sample, two's complement |
| q_in | input | 10 | Quadrature sample, two's complement |
| dec_code | input | 4 | Decimation code c: accumulate 2^c, output every 2^(c+1) |
| shift_amt | input | 3 | Right shift applied to each dump |
| oqpsk_en | input | 1 | Delay Q rail by one dump |
| out_valid | output | 1 | One-clock strobe per pair sum |
| i_out | output | 15 | In-phase pair sum |
| q_out | output | 15 | Quadrature pair sum |
| cfg_err | output | 1 | Sticky flag for an undefined decimation code |

## Verification
The hardest case to reach from the ports is a symbol strobe that lands in the middle of a partial accumulation while the pairing phase is odd. The discarded sum and the forced restart of the pair are then both visible at the output. The stimulus runs long random streams at code 3 with gapped valids and inserts sym_sync on random samples. This sets up strobes at every count and in both phases. The offset-QPSK delay is checked from the very first output, where the zero reset value of the delayed Q dump appears.

// File: rtl/idf_pkg.sv
// Package: shared types for the integrate-and-dump filter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package idf_pkg;
    // Position of a dump within its output pair.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } idf_phase_e;
endpackage

// File: rtl/idf_ctrl.sv
// Module: idf_ctrl
// Turns the decimation code and the sample strobes into per-sample control:
// start of a new accumulation, dump, and pair completion. An undefined code
// falls back to code 0 and sets a sticky error flag.
// Assumes dec_code is stable apart from reset or a following sym_sync.
module idf_ctrl
    import idf_pkg::*;
#(
    parameter int MAX_LOG = 4,
    parameter int CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sym_sync,
    input  logic [CODE_W-1:0] dec_code,
    output logic              first_o,
    output logic              dump_o,
    output logic              pair_o,
    output logic              cfg_err_o
);
    localparam int CNT_W = MAX_LOG;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_eff;
    logic [CNT_W-1:0]  len_m1;
    logic [CODE_W-1:0] code_eff;
    logic              code_bad;
    logic              last;
    idf_phase_e        phase;
    idf_phase_e        phase_eff;

    // Decode the code into an accumulation length, substituting code 0 for bad codes.
    always_comb begin
        code_bad = (dec_code > CODE_W'(MAX_LOG));
        code_eff = code_bad ? '0 : dec_code;
        len_m1   = CNT_W'((32'd1 << code_eff) - 32'd1);
    end

    // A timing strobe restarts both the sample count and the pair phase.
    always_comb begin
        cnt_eff   = sym_sync ? '0 : cnt;
        phase_eff = sym_sync ? PH_EVEN : phase;
        last      = (cnt_eff == len_m1);
        first_o   = (cnt_eff == '0);
        dump_o    = in_valid && last;
        pair_o    = dump_o && (phase_eff == PH_ODD);
    end

    // Advance the sample count and the pair phase on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= PH_EVEN;
        end else if (in_valid) begin
            cnt <= last ? '0 : cnt_eff + 1'b1;
            if (last) begin
                phase <= (phase_eff == PH_ODD) ? PH_EVEN : PH_ODD;
            end else begin
                phase <= phase_eff;
            end
        end
    end

    // Hold the error flag once an undefined code has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err_o <= 1'b0;
        end else if (code_bad) begin
            cfg_err_o <= 1'b1;
        end
    end

    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_code > CODE_W'(MAX_LOG)) |=> cfg_err_o);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
endmodule

// File: rtl/idf_chan.sv
// Module: idf_chan
// One rail of the filter: accumulator, clamped arithmetic right shifter,
// and a non-overlapping pair summer. With DELAY_OPT set, it also builds a
// path that pairs the previous odd dump with the current even dump, which
// delays the rail by half a symbol.
// Assumes the control strobes come from idf_ctrl in the same cycle.
module idf_chan #(
    parameter int IN_W      = 10,
    parameter int MAX_LOG   = 4,
    parameter int SH_W      = 3,
    parameter bit DELAY_OPT = 1'b0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic                                 first,
    input  logic                                 dump,
    input  logic                                 pair,
    input  logic [SH_W-1:0]                      shift_amt,
    input  logic                                 delay_en,
    input  logic signed [IN_W-1:0]               x,
    output logic signed [IN_W+MAX_LOG:0]         y
);
    localparam int ACC_W   = IN_W + MAX_LOG;
    localparam int OUT_W   = ACC_W + 1;
    localparam int ACC_MAX = ((1 << (IN_W - 1)) - 1) << MAX_LOG;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] sum_next;
    logic signed [ACC_W-1:0] dumped;
    logic signed [ACC_W-1:0] d_even;
    logic signed [OUT_W-1:0] y_nd;
    logic [SH_W-1:0]         sh_eff;

    // Extend the sample, accumulate it, and scale the result of a dump.
    always_comb begin
        x_ext    = {{MAX_LOG{x[IN_W-1]}}, x};
        sum_next = first ? x_ext : acc + x_ext;
        sh_eff   = (shift_amt > SH_W'(MAX_LOG)) ? SH_W'(MAX_LOG) : shift_amt;
        dumped   = sum_next >>> sh_eff;
    end

    // Register the running sum on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (in_valid) begin
            acc <= sum_next;
        end
    end

    // Keep the even dump, then add it to the odd dump when the pair completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_even <= '0;
            y_nd   <= '0;
        end else if (pair) begin
            y_nd <= {d_even[ACC_W-1], d_even} + {dumped[ACC_W-1], dumped};
        end else if (dump) begin
            d_even <= dumped;
        end
    end

    generate
        if (DELAY_OPT) begin : g_dly
            logic signed [ACC_W-1:0] d_last;
            logic signed [OUT_W-1:0] y_d;
            // Pair the previous odd dump with the current even dump.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_last <= '0;
                    y_d    <= '0;
                end else if (pair) begin
                    y_d    <= {d_last[ACC_W-1], d_last} + {d_even[ACC_W-1], d_even};
                    d_last <= dumped;
                end
            end
            assign y = delay_en ? y_d : y_nd;
        end else begin : g_nodly
            logic unused_delay_en;
            assign unused_delay_en = delay_en;
            assign y = y_nd;
        end
    endgenerate

    assert_acc_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc) <= ACC_MAX);
endmodule

// File: rtl/idf_top.sv
// Module: idf_top
// Decimating integrate-and-dump matched filter for complex baseband. One
// shared controller drives two rails. Only the Q rail is built with the
// half-symbol delay option.
// Assumes the configuration inputs stay static apart from reset or sym_sync.
module idf_top #(
    parameter int IN_W    = 10,
    parameter int MAX_LOG = 4,
    parameter int CODE_W  = 4,
    parameter int SH_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          sym_sync,
    input  logic signed [IN_W-1:0]        i_in,
    input  logic signed [IN_W-1:0]        q_in,
    input  logic [CODE_W-1:0]             dec_code,
    input  logic [SH_W-1:0]               shift_amt,
    input  logic                          oqpsk_en,
    output logic                          out_valid,
    output logic signed [IN_W+MAX_LOG:0]  i_out,
    output logic signed [IN_W+MAX_LOG:0]  q_out,
    output logic                          cfg_err
);
    localparam int OUT_W = IN_W + MAX_LOG + 1;
    localparam int NCH   = 2;

    logic first, dump, pair;
    logic signed [IN_W-1:0]  x_ch [NCH];
    logic signed [OUT_W-1:0] y_ch [NCH];

    assign x_ch[0] = i_in;
    assign x_ch[1] = q_in;

    idf_ctrl #(.MAX_LOG(MAX_LOG), .CODE_W(CODE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .sym_sync (sym_sync),
        .dec_code (dec_code),
        .first_o  (first),
        .dump_o   (dump),
        .pair_o   (pair),
        .cfg_err_o(cfg_err)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            idf_chan #(
                .IN_W     (IN_W),
                .MAX_LOG  (MAX_LOG),
                .SH_W     (SH_W),
                .DELAY_OPT(ch == 1)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (in_valid),
                .first    (first),
                .dump     (dump),
                .pair     (pair),
                .shift_amt(shift_amt),
                .delay_en ((ch == 1) ? oqpsk_en : 1'b0),
                .x        (x_ch[ch]),
                .y        (y_ch[ch])
            );
        end
    endgenerate

    assign i_out = y_ch[0];
    assign q_out = y_ch[1];

    // Register the pair-completion strobe so it lines up with the pair sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= pair;
        end
    end

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

// File: tb/tb_idf_top.sv
// Bench for idf_top: random streams with a fixed seed plus directed corners,
// checked every clock against a bench reference model.
module tb_idf_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              sym_sync = 1'b0;
    logic signed [9:0] i_in = '0;
    logic signed [9:0] q_in = '0;
    logic [3:0]        dec_code = 4'd0;
    logic [2:0]        shift_amt = 3'd0;
    logic              oqpsk_en = 1'b0;
    logic              out_valid;
    logic signed [14:0] i_out;
    logic signed [14:0] q_out;
    logic              cfg_err;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Reference model state
    int m_cnt, m_ph, m_acc_i, m_acc_q, m_ev_i, m_ev_q, m_lo_q;
    int e_i, e_q, e_v, m_err;

    always #2.5 clk = ~clk;

    idf_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_sync(sym_sync),
        .i_in(i_in), .q_in(q_in), .dec_code(dec_code), .shift_amt(shift_amt),
        .oqpsk_en(oqpsk_en), .out_valid(out_valid), .i_out(i_out),
        .q_out(q_out), .cfg_err(cfg_err)
    );

    task automatic model_clear();
        m_cnt = 0; m_ph = 0; m_acc_i = 0; m_acc_q = 0; m_ev_i = 0; m_ev_q = 0;
        m_lo_q = 0; e_i = 0; e_q = 0; e_v = 0; m_err = 0;
    endtask

    function automatic int eff_code(int c);
        return (c > 4) ? 0 : c;
    endfunction

    function automatic int eff_shift(int s);
        return (s > 4) ? 4 : s;
    endfunction

    // Advance the model by one clock edge with the currently driven inputs.
    task automatic model_edge(int v, int s, int xi, int xq);
        int len, ce, ph_e, di, dq;
        e_v = 0;
        if (dec_code > 4) m_err = 1;
        if (v != 0) begin
            ce   = (s != 0) ? 0 : m_cnt;
            ph_e = (s != 0) ? 0 : m_ph;
            len  = 1 << eff_code(int'(dec_code));
            m_acc_i = (ce == 0) ? xi : m_acc_i + xi;
            m_acc_q = (ce == 0) ? xq : m_acc_q + xq;
            if (ce == len - 1) begin
                di = m_acc_i >>> eff_shift(int'(shift_amt));
                dq = m_acc_q >>> eff_shift(int'(shift_amt));
                if (ph_e != 0) begin
                    e_i = m_ev_i + di;
                    e_q = (oqpsk_en) ? (m_lo_q + m_ev_q) : (m_ev_q + dq);
                    m_lo_q = dq;
                    e_v = 1;
                end else begin
                    m_ev_i = di;
                    m_ev_q = dq;
                end
                m_ph  = (ph_e != 0) ? 0 : 1;
                m_cnt = 0;
            end else begin
                m_cnt = ce + 1;
                m_ph  = ph_e;
            end
        end
    endtask

    task automatic compare_all();
        vectors++;
        if (int'(out_valid) != e_v) begin
            miscompares++;
            $display("FAIL %s out_valid actual=%0d expected=%0d", tag, out_valid, e_v);
        end
        if (int'(i_out) != e_i) begin
            miscompares++;
            $display("FAIL %s i_out actual=%0d expected=%0d", tag, i_out, e_i);
        end
        if (int'(q_out) != e_q) begin
            miscompares++;
            $display("FAIL %s q_out actual=%0d expected=%0d", tag, q_out, e_q);
        end
        if (int'(cfg_err) != m_err) begin
            miscompares++;
            $display("FAIL %s cfg_err actual=%0d expected=%0d", tag, cfg_err, m_err);
        end
    endtask

    // Drive one cycle (called at a negedge), then model and check after the edge.
    task automatic step(int v, int s, int xi, int xq);
        in_valid = v[0];
        sym_sync = s[0];
        i_in = 10'(xi);
        q_in = 10'(xq);
        @(posedge clk);
        #1;
        model_edge(v, s, xi, xq);
        compare_all();
        @(negedge clk);
    endtask

    task automatic do_reset(int code, int sh, int oq);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        sym_sync = 1'b0;
        dec_code = 4'(code);
        shift_amt = 3'(sh);
        oqpsk_en = oq[0];
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    function automatic int rs10();
        return int'($urandom % 1024) - 512;
    endfunction

    task automatic rand_run(int n, int vpct, int spct);
        for (int k = 0; k < n; k++) begin
            int v, s;
            v = (($urandom % 100) < vpct) ? 1 : 0;
            s = (v != 0 && ($urandom % 100) < spct) ? 1 : 0;
            step(v, s, rs10(), rs10());
        end
    endtask

    task automatic check_val(string t, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s directed actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();

        // R1: reset state
        tag = "R1";
        do_reset(2, 0, 1);
        check_val("R1", int'(out_valid), 0);
        check_val("R1", int'(i_out), 0);
        check_val("R1", int'(q_out), 0);
        check_val("R1", int'(cfg_err), 0);

        // R2: each defined code with gapped valids
        tag = "R2";
        for (int c = 0; c <= 4; c++) begin
            do_reset(c, 0, 0);
            rand_run((1 << (c + 1)) * 12, 70, 0);
        end

        // R3: shift settings including clamped values
        tag = "R3";
        for (int sh = 0; sh < 8; sh++) begin
            do_reset(3, sh, 0);
            rand_run(200, 80, 0);
        end

        // R4: directed pair sum 1+2+3+4 at code 1
        tag = "R4";
        do_reset(1, 0, 0);
        step(1, 0, 1, -1);
        step(0, 0, 99, 99);
        step(1, 0, 2, -2);
        step(1, 0, 3, -3);
        check_val("R4", int'(out_valid), 0);
        step(1, 0, 4, -4);
        check_val("R4", int'(out_valid), 1);
        check_val("R4", int'(i_out), 10);
        step(0, 0, 0, 0);
        check_val("R4", int'(out_valid), 0);
        check_val("R4", int'(i_out), 10);

        // R5: offset-QPSK delay, first output shows zero delayed dump
        tag = "R5";
        do_reset(0, 0, 1);
        step(1, 0, 5, 7);
        step(1, 0, 6, 9);
        check_val("R5", int'(q_out), 7);
        check_val("R5", int'(i_out), 11);
        step(1, 0, 1, 2);
        step(1, 0, 1, 3);
        check_val("R5", int'(q_out), 9 + 2);
        do_reset(2, 1, 1);
        rand_run(300, 75, 0);

        // R6: timing strobes at random points
        tag = "R6";
        do_reset(3, 2, 0);
        rand_run(1500, 80, 6);
        do_reset(3, 0, 1);
        rand_run(1500, 80, 6);

        // R7: undefined code acts as code 0 and latches the flag
        tag = "R7";
        do_reset(9, 0, 0);
        check_val("R7", int'(cfg_err), 0);
        step(1, 0, 3, 4);
        check_val("R7", int'(cfg_err), 1);
        step(1, 0, 5, 6);
        check_val("R7", int'(out_valid), 1);
        check_val("R7", int'(i_out), 8);
        rand_run(60, 70, 0);

        // R8: full-scale accumulation at code 4
        tag = "R8";
        do_reset(4, 0, 0);
        for (int k = 0; k < 32; k++) step(1, 0, -512, 511);
        check_val("R8", int'(i_out), -16384);
        check_val("R8", int'(q_out), 16352);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule